// File: doc/BRIEF.md
# Cross-Clock Register Write Bridge

This block carries register writes from a processor bus, timed by its own bus clock, into core logic that runs on a separate local oscillator. The two clocks have nominally the same frequency, but their phase relation is unknown and drifts slowly. The block therefore assumes no fixed relation between the edges.

On the bus side, the block registers the write strobe, address and data on the bus clock. A rising strobe captures the address and data into holding registers. The block then raises a single request level towards the core. The held vector is never synchronized bit by bit. Only the request, and the acknowledge that answers it, pass through flip-flop chains whose depth is a parameter. Each added stage lowers the metastability risk and adds one cycle of latency. The core side sees the request, copies the held vector, emits a one-cycle write pulse and raises its acknowledge. The bus side then drops the request and waits for the acknowledge to fall before it accepts the next write (four-phase handshake).

Flow control works as follows. The bus side has no ready signal. `bus_busy` stands in for not-ready, and a write whose rising strobe arrives while busy is lost and recorded in a sticky overflow bit. The core side is a valid-only stream (`core_we`) with no back-pressure: the core must take every pulse.

Top module: `cdc_wr_bridge`

## Requirements
- R1: A write is the rising edge of `bus_wr`, which is held high for at least two bus cycles. One rising edge yields at most one transfer, however long the strobe stays high.
- R2: Every accepted write yields exactly one `core_we` pulse, one core cycle wide. The pulse carries the captured address and data, and writes reach the core in the order they were accepted.
- R3: `bus_busy` rises no later than the third rising bus edge after the edge that first samples `bus_wr` high on an accepted write. It stays high until the acknowledge has returned low in the bus domain.
- R4: A write whose rising strobe is registered while `bus_busy` is high produces no core pulse and sets `bus_ovf`. `bus_ovf` then stays high until bus reset.
- R5: While `bus_busy` is high, the held address and data do not change. Once raised, the request stays high until the acknowledge is seen in the bus domain.
- R6: `core_addr` and `core_data` change only on the cycle in which `core_we` is high, and keep their values between pulses.
- R7: Each domain has its own active-high synchronous reset. After reset, `bus_busy`, `bus_ovf` and `core_we` are 0, `core_addr` and `core_data` are 0, and request and acknowledge are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Processor bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_wr | input | 1 | Write strobe, high at least two bus cycles |
| bus_addr | input | ADDR_W | Write address |
| bus_data | input | DATA_W | Write data |
| bus_busy | output | 1 | Transfer outstanding; new writes are dropped |
| bus_ovf | output | 1 | Sticky: a write was dropped while busy |
| core_clk | input | 1 | Local oscillator clock |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| core_we | output | 1 | One-cycle write pulse in the core domain |
| core_addr | output | ADDR_W | Address of the transferred write |
| core_data | output | DATA_W | Data of the transferred write |

## Verification
The bench builds the bridge with ADDR_W=6, DATA_W=12 and SYNC_STAGES=3. The three-stage chains stretch each handshake, which widens the busy window, so a second write placed just after a first one reliably lands inside it and exercises the drop path. The bus clock runs at 20 ns and the core clock at 20.3 ns, so across a few hundred writes the phase sweeps through every alignment, including edges that almost coincide. The narrow fields make address and data collisions likely, so ordering errors cannot hide behind distinct values.

// File: rtl/cdc_wr_pkg.sv
package cdc_wr_pkg;
  typedef enum logic [1:0] {
    BS_IDLE    = 2'd0,
    BS_REQ     = 2'd1,
    BS_RELEASE = 2'd2
  } bus_state_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/cdc_wr_sync.sv
module cdc_wr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned N = (STAGES < cdc_wr_pkg::MIN_SYNC_STAGES) ?
                              cdc_wr_pkg::MIN_SYNC_STAGES : STAGES;

  logic [N-1:0] chain;

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[N-1];
endmodule

// File: rtl/cdc_wr_bus_side.sv
module cdc_wr_bus_side
  import cdc_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              ack_s,
  output logic              req,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              busy,
  output logic              ovf
);
  logic              wr_q, wr_qq;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_rise;
  bus_state_e        state, state_nx;

  // input registers: nothing uses the raw bus pins directly
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      wr_qq  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q   <= wr;
      wr_qq  <= wr_q;
      addr_q <= addr;
      data_q <= data;
    end
  end

  assign wr_rise = wr_q & ~wr_qq;

  always_comb begin
    state_nx = state;
    unique case (state)
      BS_IDLE:    if (wr_rise) state_nx = BS_REQ;
      BS_REQ:     if (ack_s)   state_nx = BS_RELEASE;
      BS_RELEASE: if (!ack_s)  state_nx = BS_IDLE;
      default:                 state_nx = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= BS_IDLE;
      req       <= 1'b0;
      busy      <= 1'b0;
      ovf       <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      state <= state_nx;
      req   <= (state_nx == BS_REQ);
      busy  <= (state_nx != BS_IDLE);
      if (state == BS_IDLE && wr_rise) begin
        hold_addr <= addr_q;
        hold_data <= data_q;
      end
      if (state != BS_IDLE && wr_rise) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/cdc_wr_core_side.sv
module cdc_wr_core_side #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_s,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  output logic              ack,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic take;

  assign take = req_s & ~ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack  <= 1'b0;
      we   <= 1'b0;
      addr <= '0;
      data <= '0;
    end else begin
      we <= take;
      if (take) begin
        ack  <= 1'b1;
        addr <= hold_addr;
        data <= hold_data;
      end else if (!req_s) begin
        ack <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cdc_wr_bridge.sv
module cdc_wr_bridge #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              bus_busy,
  output logic              bus_ovf,
  input  logic              core_clk,
  input  logic              core_rst,
  output logic              core_we,
  output logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_data
);
  logic              hs_req, hs_req_core;
  logic              hs_ack, hs_ack_bus;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  cdc_wr_bus_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(bus_clk), .rst(bus_rst), .wr(bus_wr), .addr(bus_addr), .data(bus_data),
    .ack_s(hs_ack_bus), .req(hs_req), .hold_addr(hold_addr), .hold_data(hold_data),
    .busy(bus_busy), .ovf(bus_ovf)
  );

  cdc_wr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(core_clk), .rst(core_rst), .d(hs_req), .q(hs_req_core)
  );

  cdc_wr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst(bus_rst), .d(hs_ack), .q(hs_ack_bus)
  );

  cdc_wr_core_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk(core_clk), .rst(core_rst), .req_s(hs_req_core),
    .hold_addr(hold_addr), .hold_data(hold_data),
    .ack(hs_ack), .we(core_we), .addr(core_addr), .data(core_data)
  );
endmodule

// File: rtl/cdc_wr_bridge_chk.sv
module cdc_wr_bridge_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input logic              bus_clk,
  input logic              bus_rst,
  input logic              core_clk,
  input logic              core_rst,
  input logic              bus_busy,
  input logic              bus_ovf,
  input logic              req,
  input logic              ack_bs,
  input logic [ADDR_W-1:0] hold_addr,
  input logic [DATA_W-1:0] hold_data,
  input logic              core_we,
  input logic [ADDR_W-1:0] core_addr,
  input logic [DATA_W-1:0] core_data
);
  // R5
  hold_stable_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    bus_busy |=> ($stable(hold_addr) && $stable(hold_data)));

  // R5
  req_held_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (req && !ack_bs) |=> req);

  // R3
  idle_no_req_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    !bus_busy |-> !req);

  // R4
  ovf_sticky_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    bus_ovf |=> bus_ovf);

  // R2
  we_single_chk: assert property (@(posedge core_clk) disable iff (core_rst)
    core_we |=> !core_we);

  // R6
  core_hold_chk: assert property (@(posedge core_clk) disable iff (core_rst)
    !core_we |-> ($stable(core_addr) && $stable(core_data)));
endmodule

bind cdc_wr_bridge cdc_wr_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .core_clk(core_clk), .core_rst(core_rst),
  .bus_busy(bus_busy), .bus_ovf(bus_ovf), .req(hs_req), .ack_bs(hs_ack_bus),
  .hold_addr(hold_addr), .hold_data(hold_data), .core_we(core_we),
  .core_addr(core_addr), .core_data(core_data)
);

// File: tb/cdc_wr_bridge_bench.sv
`timescale 1ns/1ps
module cdc_wr_bridge_bench;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 12;
  localparam int unsigned VW = AW + DW;

  logic bus_clk = 1'b0, core_clk = 1'b0;
  logic bus_rst = 1'b1, core_rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic bus_busy, bus_ovf, core_we;
  logic [AW-1:0] core_addr;
  logic [DW-1:0] core_data;

  always #10    bus_clk  = ~bus_clk;
  always #10.15 core_clk = ~core_clk;

  cdc_wr_bridge #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(3)) u_cdc_wr_bridge (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_busy(bus_busy), .bus_ovf(bus_ovf),
    .core_clk(core_clk), .core_rst(core_rst), .core_we(core_we),
    .core_addr(core_addr), .core_data(core_data)
  );

  int checks = 0, errors = 0;
  int pulses = 0, pushed = 0;
  logic [VW-1:0] expq[$];
  logic [VW-1:0] last_vec = '0;
  bit check_hold = 0;
  bit done = 0;

  function automatic logic [VW-1:0] pack_vec(logic [AW-1:0] a, logic [DW-1:0] d);
    return {a, d};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // core-side monitor: R2 content/order, R6 hold after a pulse
  always @(negedge core_clk) begin
    if (!core_rst) begin
      if (check_hold) begin
        check_hold <= 0;
        // R6: outputs keep the transferred vector once the pulse has gone
        chk(!core_we && pack_vec(core_addr, core_data) == last_vec, "R6",
            32'(pack_vec(core_addr, core_data)), 32'(last_vec));
      end
      if (core_we) begin
        pulses++;
        if (expq.size() == 0) begin
          // R2 / R4: a pulse with nothing outstanding
          chk(0, "R2", 32'(pack_vec(core_addr, core_data)), 32'hFFFFFFFF);
        end else begin
          logic [VW-1:0] e;
          e = expq.pop_front();
          chk(pack_vec(core_addr, core_data) == e, "R2",
              32'(pack_vec(core_addr, core_data)), 32'(e));
        end
        last_vec   <= pack_vec(core_addr, core_data);
        check_hold <= 1;
      end
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge bus_clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic bus_cycles(int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic wait_idle();
    while (bus_busy) @(negedge bus_clk);
  endtask

  task automatic issue(logic [AW-1:0] a, logic [DW-1:0] d, int hold, bit expect_accept);
    bus_addr = a;
    bus_data = d;
    bus_wr   = 1'b1;
    if (expect_accept) begin
      expq.push_back(pack_vec(a, d));
      pushed++;
    end
    bus_cycles(hold);
    bus_wr   = 1'b0;
    bus_addr = $urandom();
    bus_data = $urandom();
  endtask

  task automatic drain();
    int t = 0;
    while ((expq.size() != 0 || bus_busy) && t < 2000) begin
      @(negedge bus_clk);
      t++;
    end
    bus_cycles(20);
  endtask

  task automatic do_reset();
    bus_rst  = 1'b1;
    core_rst = 1'b1;
    bus_cycles(6);
    bus_rst  = 1'b0;
    core_rst = 1'b0;
    bus_cycles(2);
  endtask

  initial begin
    void'($urandom(32'd1357));
    do_reset();
    // R7: reset state
    chk(bus_busy == 0, "R7", 32'(bus_busy), 0);
    chk(bus_ovf == 0, "R7", 32'(bus_ovf), 0);
    chk(core_we == 0, "R7", 32'(core_we), 0);
    chk(core_addr == 0 && core_data == 0, "R7", 32'(pack_vec(core_addr, core_data)), 0);

    // R3: busy rises by the third bus edge after the strobe is first sampled
    issue(6'h2A, 12'h5C3, 2, 1);
    bus_cycles(1);
    chk(bus_busy == 1, "R3", 32'(bus_busy), 1);
    // R4: a second rising strobe while busy is dropped
    issue(6'h15, 12'hA3C, 2, 0);
    bus_cycles(2);
    chk(bus_ovf == 1, "R4", 32'(bus_ovf), 1);
    drain();
    chk(expq.size() == 0, "R4", 32'(expq.size()), 0);
    chk(pulses == 1, "R4", 32'(pulses), 1);

    // R1: a long strobe gives one transfer only
    issue(6'h3F, 12'hFFF, 30, 1);
    drain();
    chk(pulses == 2, "R1", 32'(pulses), 2);
    // R4: overflow still sticky after later accepted writes
    chk(bus_ovf == 1, "R4", 32'(bus_ovf), 1);

    // R3: busy falls only once the handshake completes (nothing pending)
    chk(bus_busy == 0, "R3", 32'(bus_busy), 0);

    // R7 / R4: reset clears the sticky bit
    do_reset();
    chk(bus_ovf == 0, "R7", 32'(bus_ovf), 0);
    chk(core_addr == 0 && core_data == 0, "R7", 32'(pack_vec(core_addr, core_data)), 0);
    pulses = 0;
    pushed = 0;

    // boundary values back to back
    wait_idle();
    issue('0, '0, 2, 1);
    wait_idle();
    issue('1, '1, 2, 1);

    // R1/R2: random writes, random gaps and hold lengths, phase sweeping
    for (int i = 0; i < 300; i++) begin
      wait_idle();
      bus_cycles($urandom_range(0, 3));
      issue(AW'($urandom()), DW'($urandom()), $urandom_range(2, 5), 1);
    end
    drain();
    chk(expq.size() == 0, "R2", 32'(expq.size()), 0);
    chk(pulses == pushed, "R2", 32'(pulses), 32'(pushed));
    chk(bus_ovf == 0, "R4", 32'(bus_ovf), 0);

    done = 1;
    finish_run();
  end
endmodule